// File: doc/BRIEF.md
# Power-Mode Control Register and Clock Gating

This block holds the byte-wide power-mode register of an 8051-class microcontroller and turns its contents into clocks. The CPU writes and reads the register as a whole byte on the special-function-register bus at address 87h. Two request bits pick a low-power state. The idle request stops the CPU clock while the peripheral clock keeps running for timers, the serial port and the interrupt logic. The power-down request drops the oscillator enable and stops both gated clocks. When both requests arrive in the same write, power-down is taken.

A wake input from the interrupt controller leaves idle. Only reset leaves power-down. The register also holds the serial baud-doubling bit, which goes straight out to the serial port, and two general flags that drive no hardware. Each gated clock comes from a level-sensitive enable latch that is transparent only while the source clock is low, so an enable change never cuts a clock pulse short.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, a read at address 87h returns 70h, `osc_en` is 1, `baud_dbl` is 0 and both gated clocks pulse.
- R2: A byte write (`sfr_wr`=1, `sfr_bitwr`=0) at address 87h stores bit 7 (baud double), bit 3 and bit 2 (general flags), bit 1 (power-down) and bit 0 (idle). A read at 87h returns them in the same positions. Writes to any other address change nothing.
- R3: Bits 6 to 4 always read as 1, and writing them has no effect. A read at any address other than 87h returns 00h.
- R4: From the edge that stores power-down = 1, `osc_en` is 0, and `cpu_clk` and `per_clk` give no further pulses.
- R5: From the edge that stores idle = 1 with power-down = 0, `cpu_clk` gives no further pulses, while `per_clk` keeps pulsing and `osc_en` stays 1.
- R6: A write with both bit 1 and bit 0 set stores power-down = 1 and idle = 0.
- R7: `irq_wake` sampled high clears the idle bit at that edge, which takes priority over a write setting idle in the same cycle. Pulses of `cpu_clk` resume in the following cycle. `irq_wake` has no effect on power-down.
- R8: A write with `sfr_bitwr`=1 leaves the register unchanged at every address.
- R9: `baud_dbl` equals the stored bit 7.
- R10: Each gated clock is low whenever `clk` is low, and it holds one level through the whole high phase of `clk`.
- R11: Reset clears power-down and idle and brings back all clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | ADDR_W | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_bitwr | input | 1 | Qualifies the write as a single-bit operation |
| sfr_wdata | input | 8 | SFR write data |
| irq_wake | input | 1 | Enabled interrupt request pending |
| sfr_rdata | output | 8 | Read data, 00h when not addressed |
| osc_en | output | 1 | Oscillator run enable |
| cpu_clk | output | 1 | Gated CPU clock |
| per_clk | output | 1 | Gated peripheral clock |
| baud_dbl | output | 1 | Baud-rate doubling to the serial port |

## Verification
The bench goes after the write that sets both request bits. A design without the precedence rule would be left in idle with the oscillator still running, or would report idle set while powered down. It drives wake in the same cycle as an idle-setting write, where wrong priority strands the CPU clock off. It also sends bit-write strobes and writes to neighbouring addresses, which a loose decoder would let through to the register. Every cycle, each gated clock is sampled early and late in the high phase and again in the low phase. An enable that is not latched on the low phase would show up as a clipped pulse or a clock high while `clk` is low.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_SMOD = 7;
    localparam int BIT_GF1  = 3;
    localparam int BIT_GF0  = 2;
    localparam int BIT_PD   = 1;
    localparam int BIT_IDL  = 0;
    localparam logic [2:0] RSV_READ = 3'b111;
    localparam int CLK_CPU  = 0;
    localparam int CLK_PER  = 1;
    localparam int NUM_CLK  = 2;

    typedef struct packed {
        logic smod;
        logic gf1;
        logic gf0;
        logic pd;
        logic idl;
    } pmode_t;
endpackage

// File: rtl/pwrmode_decode.sv
module pwrmode_decode
    import pwrmode_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h87
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              bitwr,
    input  pmode_t            st,
    output logic              wr_hit,
    output logic [DATA_W-1:0] rdata
);
    logic sel;

    always_comb begin
        sel    = (addr == REG_ADDR);
        wr_hit = sel && wr && !bitwr;
        rdata  = '0;
        if (sel) begin
            rdata[BIT_SMOD]   = st.smod;
            rdata[6:4]        = RSV_READ;
            rdata[BIT_GF1]    = st.gf1;
            rdata[BIT_GF0]    = st.gf0;
            rdata[BIT_PD]     = st.pd;
            rdata[BIT_IDL]    = st.idl;
        end
    end
endmodule

// File: rtl/pwrmode_regs.sv
module pwrmode_regs
    import pwrmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake,
    output pmode_t            st_q,
    output logic [NUM_CLK-1:0] clk_en_q
);
    typedef struct packed {
        pmode_t             st;
        logic [NUM_CLK-1:0] en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_hit) begin
            r_d.st.smod = wdata[BIT_SMOD];
            r_d.st.gf1  = wdata[BIT_GF1];
            r_d.st.gf0  = wdata[BIT_GF0];
            r_d.st.pd   = wdata[BIT_PD];
            // power-down wins over idle in one write
            r_d.st.idl  = wdata[BIT_IDL] && !wdata[BIT_PD];
        end
        if (wake) begin
            r_d.st.idl = 1'b0;
        end
        r_d.en[CLK_CPU] = !r_d.st.pd && !r_d.st.idl;
        r_d.en[CLK_PER] = !r_d.st.pd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= '0;
            r_q.en <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q     = r_q.st;
    assign clk_en_q = r_q.en;
endmodule

// File: rtl/pwrmode_cgate.sv
module pwrmode_cgate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_l;

    always_latch begin
        if (!clk_in) begin
            en_l = en;
        end
    end

    assign clk_out = clk_in & en_l;
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_bitwr,
    input  logic [7:0]        sfr_wdata,
    input  logic              irq_wake,
    output logic [7:0]        sfr_rdata,
    output logic              osc_en,
    output logic              cpu_clk,
    output logic              per_clk,
    output logic              baud_dbl
);
    pmode_t             st_q;
    logic               wr_hit;
    logic [NUM_CLK-1:0] clk_en_q;
    logic [NUM_CLK-1:0] gclk;
    logic               pd_now;
    logic               idl_now;

    pwrmode_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr  (sfr_addr),
        .wr    (sfr_wr),
        .bitwr (sfr_bitwr),
        .st    (st_q),
        .wr_hit(wr_hit),
        .rdata (sfr_rdata)
    );

    pwrmode_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (sfr_wdata),
        .wake    (irq_wake),
        .st_q    (st_q),
        .clk_en_q(clk_en_q)
    );

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_gate
        pwrmode_cgate u_cg (
            .clk_in (clk),
            .en     (clk_en_q[g]),
            .clk_out(gclk[g])
        );
    end

    assign pd_now   = st_q.pd;
    assign idl_now  = st_q.idl;
    assign osc_en   = !pd_now;
    assign cpu_clk  = gclk[CLK_CPU];
    assign per_clk  = gclk[CLK_PER];
    assign baud_dbl = st_q.smod;
endmodule

// File: rtl/pwrmode_chk.sv
module pwrmode_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h87
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic              sfr_bitwr,
    input logic [7:0]        sfr_wdata,
    input logic              irq_wake,
    input logic [7:0]        sfr_rdata,
    input logic              osc_en,
    input logic              pd_now,
    input logic              idl_now,
    input logic              baud_dbl
);
    logic byte_hit;
    assign byte_hit = sfr_wr && !sfr_bitwr && (sfr_addr == REG_ADDR);

    AST_PD_STOPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && sfr_wdata[1]) |=> !osc_en); // R4
    AST_PD_OVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && sfr_wdata[1] && sfr_wdata[0]) |=> (pd_now && !idl_now)); // R6
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |=> !idl_now); // R7
    AST_WAKE_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wake && !byte_hit) |=> (pd_now == $past(pd_now))); // R7
    AST_BITWR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_bitwr && !irq_wake) |=> $stable({baud_dbl, pd_now, idl_now})); // R8
    AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == REG_ADDR) |-> (sfr_rdata[6:4] == 3'b111)); // R3
    AST_SMOD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == REG_ADDR) |-> (sfr_rdata[7] == baud_dbl)); // R9
endmodule

bind pwrmode_ctrl pwrmode_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sfr_addr (sfr_addr),
    .sfr_wr   (sfr_wr),
    .sfr_bitwr(sfr_bitwr),
    .sfr_wdata(sfr_wdata),
    .irq_wake (irq_wake),
    .sfr_rdata(sfr_rdata),
    .osc_en   (osc_en),
    .pd_now   (pd_now),
    .idl_now  (idl_now),
    .baud_dbl (baud_dbl)
);

// File: tb/tb_pwrmode_ctrl.sv
`timescale 1ns/1ps
module tb_pwrmode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_bitwr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic       irq_wake = 1'b0;
    logic [7:0] sfr_rdata;
    logic       osc_en, cpu_clk, per_clk, baud_dbl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model
    logic m_smod, m_gf1, m_gf0, m_pd, m_idl;

    always #(HALF) clk = ~clk;

    pwrmode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_bitwr(sfr_bitwr), .sfr_wdata(sfr_wdata), .irq_wake(irq_wake),
        .sfr_rdata(sfr_rdata), .osc_en(osc_en), .cpu_clk(cpu_clk),
        .per_clk(per_clk), .baud_dbl(baud_dbl)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a != 8'h87) return 8'h00;
        return {m_smod, 3'b111, m_gf1, m_gf0, m_pd, m_idl};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // one bus cycle: called just after a falling edge
    task automatic cycle(input logic wr, input logic bw, input logic [7:0] a,
                         input logic [7:0] d, input logic wk);
        logic old_cpu, old_per;
        old_cpu = !m_pd && !m_idl;
        old_per = !m_pd;
        sfr_wr = wr; sfr_bitwr = bw; sfr_addr = a; sfr_wdata = d; irq_wake = wk;
        @(posedge clk);
        if (wr && !bw && a == 8'h87) begin
            m_smod = d[7]; m_gf1 = d[3]; m_gf0 = d[2]; m_pd = d[1];
            m_idl = d[0] && !d[1]; // R6
        end
        if (wk) m_idl = 1'b0; // R7
        #1;
        chk("R5/R4 cpu_clk early high", {7'd0, cpu_clk}, {7'd0, old_cpu});
        chk("R4 per_clk early high", {7'd0, per_clk}, {7'd0, old_per});
        chk("R4 osc_en", {7'd0, osc_en}, {7'd0, !m_pd});
        chk("R2/R3/R8 readback", sfr_rdata, exp_read(a));
        chk("R9 baud_dbl", {7'd0, baud_dbl}, {7'd0, m_smod});
        #(HALF - 2);
        chk("R10 cpu_clk late high", {7'd0, cpu_clk}, {7'd0, old_cpu});
        chk("R10 per_clk late high", {7'd0, per_clk}, {7'd0, old_per});
        @(negedge clk);
        #1;
        chk("R10 gated low in low phase", {6'd0, cpu_clk, per_clk}, 8'd0);
        sfr_wr = 1'b0; sfr_bitwr = 1'b0; irq_wake = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_smod = 0; m_gf1 = 0; m_gf0 = 0; m_pd = 0; m_idl = 0;
        sfr_addr = 8'h87;
        #1;
        chk("R1/R11 reset read", sfr_rdata, 8'h70);
        chk("R1/R11 reset osc_en", {7'd0, osc_en}, 8'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        do_reset();
        // R1: clocks run after reset
        cycle(0, 0, 8'h87, 8'h00, 0);
        // R2/R3: write flags and reserved bits, read back
        cycle(1, 0, 8'h87, 8'hFC, 0);
        cycle(0, 0, 8'h87, 8'h00, 0);
        cycle(0, 0, 8'h86, 8'h00, 0); // R3 other address reads 0
        // R2: write to neighbour address ignored
        cycle(1, 0, 8'h88, 8'h03, 0);
        // R8: bit write ignored
        cycle(1, 1, 8'h87, 8'h01, 0);
        // R5: idle then wake R7
        cycle(1, 0, 8'h87, 8'h01, 0);
        cycle(0, 0, 8'h87, 8'h00, 0);
        cycle(0, 0, 8'h87, 8'h00, 0);
        cycle(0, 0, 8'h87, 8'h00, 1);
        cycle(0, 0, 8'h87, 8'h00, 0);
        // R7: wake beats same-cycle idle set
        cycle(1, 0, 8'h87, 8'h01, 1);
        cycle(0, 0, 8'h87, 8'h00, 0);
        // R6: both bits set, PD wins; R7 wake leaves PD
        cycle(1, 0, 8'h87, 8'h83, 0);
        cycle(0, 0, 8'h87, 8'h00, 1);
        cycle(0, 0, 8'h87, 8'h00, 0);
        // R11: reset leaves power-down
        do_reset();
        cycle(0, 0, 8'h87, 8'h00, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, d;
            logic w, b, k;
            if (m_pd) begin
                do_reset();
            end else begin
                a = ($urandom % 4 == 0) ? 8'($urandom) : 8'h87;
                d = 8'($urandom);
                if ($urandom % 3 != 0) d[1] = 1'b0;
                w = ($urandom % 2) == 0;
                b = ($urandom % 5) == 0;
                k = ($urandom % 4) == 0;
                cycle(w, b, a, d, k);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule